// File: doc/BRIEF.md
# Low-Power Domain Write Bridge

This block carries register writes from a fast bus clock into a slow, always-on clock domain of about 32 kHz. When a write is accepted, its address and data are latched and held in the bus domain. A single request toggle then crosses into the slow domain. There the write is applied as one strobe, and an acknowledge toggle returns to the bus domain. The block publishes four status flags on the bus side: busy, ready-for-next, complete and error. It raises one interrupt line from whichever of ready-for-next, complete and error are enabled.

One address is the interrupt-enable register. Writes to it are never forwarded and take effect on the next bus clock. A read of the status register clears the complete flag; the bus signals that read with `stat_rd`. A write that arrives while the bridge is still busy is dropped and sets a sticky error flag. That flag is cleared by a synchronized write to the status address with data bit 7 set, at the moment that write completes.

The slow-domain registers themselves live outside this block. They take `slow_wr_en`, `slow_wr_addr` and `slow_wr_data` on `slow_clk`.

Top module: `lpw_write_bridge`

## Requirements
- R1: A write accepted on the bus side (address not the enable register, bridge not busy) produces exactly one single-cycle `slow_wr_en` pulse carrying that write's address and data.
- R2: Status bit 10 (busy) is 1 from the bus cycle after acceptance until the returning acknowledge is seen. Status bit 9 (ready-for-next) is its inverse.
- R3: Status bit 8 (complete) becomes 1 in the bus cycle after the acknowledge of a forwarded write is seen.
- R4: A `stat_rd` pulse clears status bit 8. A completion in the same cycle wins and leaves it set.
- R5: A write to `IEN_ADDR` loads `ien_o` bits 9, 8 and 7 from the write data on the next bus clock. The other `ien_o` bits read 0. Such a write never sets busy or complete and is never forwarded.
- R6: A non-enable write that arrives while busy is discarded (never forwarded) and sets status bit 7 (error). The bit stays set across unrelated writes and reads.
- R7: Status bit 7 is cleared when a forwarded write to `STAT_ADDR` with data bit 7 = 1 completes. A status write with data bit 7 = 0 leaves it set. Both set complete like any forwarded write.
- R8: `irq` is the OR of (status bit 9 AND `ien_o` bit 9), (status bit 8 AND `ien_o` bit 8) and (status bit 7 AND `ien_o` bit 7).
- R9: After reset, status reads only bit 9 set, `ien_o` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| slow_clk | input | 1 | Slow low-power clock |
| slow_rst_n | input | 1 | Active-low reset, slow domain |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Bus write address |
| wr_data | input | DW | Bus write data |
| stat_rd | input | 1 | Status-register read strobe |
| status_o | output | SW | Status flags (bits 10, 9, 8, 7) |
| ien_o | output | SW | Interrupt-enable register |
| irq | output | 1 | Interrupt request |
| slow_wr_en | output | 1 | Write strobe into slow-domain registers |
| slow_wr_addr | output | AW | Held write address |
| slow_wr_data | output | DW | Held write data |

## Verification
A table of writes to different addresses and data patterns checks two things: that each lands once in a slow-domain model and that the flags follow the busy, ready and complete sequence. Back-to-back writes tell a dropped write apart from a queued one, because the second address must stay untouched and raise the error flag. Status writes with data bit 7 at 0 and then at 1 tell the error-clear rule apart from the plain completion of a write. Enable-register writes taken alone, and then a status read that coincides with none, a completion or a pending interrupt, separate the bus-speed path and the interrupt masking from the synchronized path.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
   // Status / enable bit positions decoded by software
   localparam int BIT_BUSY = 10;
   localparam int BIT_NEXT = 9;
   localparam int BIT_DONE = 8;
   localparam int BIT_ERR  = 7;
   localparam int MIN_SW   = 11;
endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lpw_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lpw_slow_side.sv
module lpw_slow_side (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   output logic strobe,
   output logic ack_tgl
);
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= req_s;

   assign strobe  = req_s ^ seen_q;
   assign ack_tgl = seen_q;

   // R1: each request toggle yields a single-cycle strobe
   a_r1_single_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
endmodule

// File: rtl/lpw_bus_side.sv
module lpw_bus_side
   import lpw_pkg::*;
#(
   parameter int          AW        = 4,
   parameter int          DW        = 32,
   parameter int          SW        = 16,
   parameter logic [AW-1:0] IEN_ADDR  = '0,
   parameter logic [AW-1:0] STAT_ADDR = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          stat_rd,
   input  logic          ack_s,
   output logic          req_tgl,
   output logic [AW-1:0] hold_addr,
   output logic [DW-1:0] hold_data,
   output logic [SW-1:0] status_o,
   output logic [SW-1:0] ien_o,
   output logic          irq
);
   logic          busy_q, done_q, err_q, req_q;
   logic [2:0]    ien_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          is_ien, accept, collide, done, clr_err;

   assign is_ien  = (wr_addr == IEN_ADDR);
   assign accept  = wr_en && !is_ien && !busy_q;
   assign collide = wr_en && !is_ien &&  busy_q;
   assign done    = busy_q && (ack_s == req_q);
   assign clr_err = done && (addr_q == STAT_ADDR) && data_q[BIT_ERR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         req_q  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         req_q  <= ~req_q;
         addr_q <= wr_addr;
         data_q <= wr_data;
      end else if (done) begin
         busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       done_q <= 1'b0;
      else if (done)    done_q <= 1'b1;
      else if (stat_rd) done_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (collide) err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ien_q <= '0;
      else if (wr_en && is_ien)  ien_q <= wr_data[BIT_NEXT:BIT_ERR];
   end

   always_comb begin
      status_o           = '0;
      status_o[BIT_BUSY] = busy_q;
      status_o[BIT_NEXT] = !busy_q;
      status_o[BIT_DONE] = done_q;
      status_o[BIT_ERR]  = err_q;
      ien_o                   = '0;
      ien_o[BIT_NEXT:BIT_ERR] = ien_q;
   end

   assign irq = (ien_q[2] && !busy_q) || (ien_q[1] && done_q) || (ien_q[0] && err_q);
   assign req_tgl   = req_q;
   assign hold_addr = addr_q;
   assign hold_data = data_q;

   a_r2_busy_after_accept : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> status_o[BIT_BUSY]);
   a_r2_hold_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> ($stable(hold_data) && $stable(hold_addr)));
   a_r3_done_sets_flag : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> status_o[BIT_DONE]);
   a_r4_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !done) |=> !status_o[BIT_DONE]);
   a_r5_ien_no_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_ien && !busy_q) |=> !status_o[BIT_BUSY]);
   a_r6_collision_err : assert property (@(posedge clk) disable iff (!rst_n)
      collide |=> (status_o[BIT_ERR] && $stable(req_tgl)));
endmodule

// File: rtl/lpw_write_bridge.sv
module lpw_write_bridge
   import lpw_pkg::*;
#(
   parameter int          AW          = 4,
   parameter int          DW          = 32,
   parameter int          SW          = 16,
   parameter int          SYNC_STAGES = 2,
   parameter logic [AW-1:0] STAT_ADDR   = 4'hA,
   parameter logic [AW-1:0] IEN_ADDR    = 4'hB
) (
   input  logic          bus_clk,
   input  logic          bus_rst_n,
   input  logic          slow_clk,
   input  logic          slow_rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          stat_rd,
   output logic [SW-1:0] status_o,
   output logic [SW-1:0] ien_o,
   output logic          irq,
   output logic          slow_wr_en,
   output logic [AW-1:0] slow_wr_addr,
   output logic [DW-1:0] slow_wr_data
);
   logic req_tgl, req_s, ack_tgl, ack_s;

   generate
      if (SW < MIN_SW) begin : g_bad_sw
         $error("lpw_write_bridge: SW must hold bit 10");
      end
      if (DW < SW) begin : g_bad_dw
         $error("lpw_write_bridge: DW must be at least SW");
      end
      if (STAT_ADDR == IEN_ADDR) begin : g_bad_addr
         $error("lpw_write_bridge: status and enable addresses must differ");
      end
   endgenerate

   lpw_bus_side #(
      .AW(AW), .DW(DW), .SW(SW), .IEN_ADDR(IEN_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_bus (
      .clk(bus_clk), .rst_n(bus_rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd),
      .ack_s(ack_s), .req_tgl(req_tgl),
      .hold_addr(slow_wr_addr), .hold_data(slow_wr_data),
      .status_o(status_o), .ien_o(ien_o), .irq(irq)
   );

   lpw_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_s)
   );

   lpw_slow_side u_slow (
      .clk(slow_clk), .rst_n(slow_rst_n), .req_s(req_s),
      .strobe(slow_wr_en), .ack_tgl(ack_tgl)
   );

   lpw_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_s)
   );
endmodule

// File: tb/lpw_write_bridge_tb.sv
module lpw_write_bridge_tb;
   localparam int AW = 4, DW = 32, SW = 16;
   localparam logic [AW-1:0] STAT_A = 4'hA, IEN_A = 4'hB;

   logic bus_clk = 0, slow_clk = 0, rst_n = 0;
   logic wr_en = 0, stat_rd = 0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [SW-1:0] status_o, ien_o;
   logic irq, slow_wr_en;
   logic [AW-1:0] slow_wr_addr;
   logic [DW-1:0] slow_wr_data;

   int checks = 0, failures = 0, strobes = 0;
   bit finished = 0;
   logic [DW-1:0] regs [16];

   always #2.5 bus_clk = ~bus_clk;
   always #80  slow_clk = ~slow_clk;

   lpw_write_bridge #(.AW(AW), .DW(DW), .SW(SW), .STAT_ADDR(STAT_A), .IEN_ADDR(IEN_A)) u_dut (
      .bus_clk(bus_clk), .bus_rst_n(rst_n), .slow_clk(slow_clk), .slow_rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd),
      .status_o(status_o), .ien_o(ien_o), .irq(irq),
      .slow_wr_en(slow_wr_en), .slow_wr_addr(slow_wr_addr), .slow_wr_data(slow_wr_data)
   );

   // slow-domain register file model
   always @(posedge slow_clk) if (slow_wr_en) begin
      regs[slow_wr_addr] <= slow_wr_data;
      strobes <= strobes + 1;
   end

   localparam logic [AW-1:0] VA [4] = '{4'h1, 4'h2, 4'h7, 4'hF};
   localparam logic [DW-1:0] VD [4] = '{32'hDEAD_BEEF, 32'h0000_0001, 32'hFFFF_FFFF, 32'h5A5A_A5A5};

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge bus_clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge bus_clk); wr_en = 0;
   endtask

   task automatic do_read();
      @(negedge bus_clk); stat_rd = 1;
      @(negedge bus_clk); stat_rd = 0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (status_o[10] && n < 4000) begin @(negedge bus_clk); n++; end
      chk("R2 busy drop", {31'd0, status_o[10]}, 32'd0);
      repeat (40) @(negedge bus_clk);  // let slow model settle
   endtask

   initial begin
      for (int i = 0; i < 16; i++) regs[i] = '0;
      repeat (4) @(negedge bus_clk);
      rst_n = 1;
      @(negedge bus_clk);
      // R9 reset state
      chk("R9 status", {16'd0, status_o}, 32'h0000_0200);
      chk("R9 ien", {16'd0, ien_o}, 32'd0);
      chk("R9 irq", {31'd0, irq}, 32'd0);

      // table walk: R1 R2 R3 R4
      for (int v = 0; v < 4; v++) begin
         do_write(VA[v], VD[v]);
         chk("R2 busy set", {16'd0, status_o & 16'h0600}, 32'h0400);
         wait_idle();
         chk("R1 data landed", regs[VA[v]], VD[v]);
         chk("R3 complete set", {31'd0, status_o[8]}, 32'd1);
         chk("R2 next high", {31'd0, status_o[9]}, 32'd1);
         do_read();
         chk("R4 read clears", {31'd0, status_o[8]}, 32'd0);
      end
      chk("R1 strobe count", strobes, 32'd4);

      // R5 enable write at bus speed
      do_write(IEN_A, 32'hFFFF_FFFF);
      chk("R5 ien value", {16'd0, ien_o}, 32'h0000_0380);
      chk("R5 no busy", {31'd0, status_o[10]}, 32'd0);
      chk("R5 no complete", {31'd0, status_o[8]}, 32'd0);
      repeat (200) @(negedge bus_clk);
      chk("R5 not forwarded", regs[IEN_A], 32'd0);
      chk("R8 irq from next", {31'd0, irq}, 32'd1);

      // R8 complete-only enable
      do_write(IEN_A, 32'h0000_0100);
      chk("R8 masked next", {31'd0, irq}, 32'd0);
      do_write(4'h3, 32'h1234_5678);
      wait_idle();
      chk("R8 irq from complete", {31'd0, irq}, 32'd1);
      do_read();
      chk("R8 irq after read", {31'd0, irq}, 32'd0);

      // R6 collision
      do_write(4'h4, 32'hAAAA_0004);
      do_write(4'h9, 32'hBBBB_0009);
      chk("R6 error set", {31'd0, status_o[7]}, 32'd1);
      chk("R8 error masked", {31'd0, irq}, 32'd0);
      wait_idle();
      chk("R6 first landed", regs[4'h4], 32'hAAAA_0004);
      chk("R6 dropped", regs[4'h9], 32'd0);
      do_write(IEN_A, 32'h0000_0080);
      chk("R8 irq from error", {31'd0, irq}, 32'd1);
      do_read();
      do_write(4'h5, 32'h0000_0080);  // non-status write with bit7
      wait_idle();
      chk("R6 sticky", {31'd0, status_o[7]}, 32'd1);

      // R7 status write, bit7 clear then set
      do_write(STAT_A, 32'h0000_0000);
      wait_idle();
      chk("R7 bit7=0 keeps", {31'd0, status_o[7]}, 32'd1);
      chk("R7 completes", {31'd0, status_o[8]}, 32'd1);
      do_write(STAT_A, 32'h0000_0080);
      chk("R7 held until done", {31'd0, status_o[7]}, 32'd1);
      wait_idle();
      chk("R7 cleared", {31'd0, status_o[7]}, 32'd0);
      chk("R8 irq gone", {31'd0, irq}, 32'd0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge bus_clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule